// File: doc/BRIEF.md
# Multicycle Word-Fetch Sequencer

A small multicycle processor with three general registers (R1, R2, R3) and five operations: a load from an absolute address, a load through R1, a register add, a store to an absolute address, and halt. Program and data share one word-addressed memory inside the block. The memory is restored to a parameterised image whenever reset is asserted.

Timing is fixed and easy to predict. Each instruction word costs a fixed number of fetch/decode cycles, and each execute phase costs a fixed number of wait cycles set by its class. A host pulses `start_i`, waits for `halted_o`, and then reads the final registers and the total cycle count.

Top module: `wordseq_cpu`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `halted_o` is 0, `cycles_o` is 0 and all three registers read 0. Reset also restores the memory to its image. The block then idles and does not count until it is started.
- R2: A `start_i` pulse seen in the idle state begins execution at word address 0 with the cycle count at 0. `start_i` has no effect while the block is running or halted.
- R3: Instruction encoding:
  - Bits [15:13] of the first word hold the opcode: 0 = halt, 1 = direct load, 2 = indirect load, 3 = add, 4 = direct store.
  - Bits [12:11] of the first word select the register: 1..3 select R1..R3, and 0 selects none.
  - A two-word instruction (direct load or direct store) carries its absolute address in bits [7:0] of its second word.
- R4: Every instruction word costs exactly 2 fetch/decode cycles.
- R5: Execute costs by class:
  - Any memory transfer (both loads and the store) costs 3 execute cycles.
  - The add costs 1 execute cycle.
  - Halt costs none.
  - A register written by an instruction is visible on the register ports after its last execute cycle.
- R6: A direct load writes memory[address] into the selected register. An indirect load writes memory[R1[7:0]] into R2.
- R7: The add computes R2 = R2 + R3 modulo 2^16.
- R8: A direct store writes the selected register to memory[address], and a later load of that address returns the stored value.
- R9: `cycles_o` rises by one on every cycle from start until halt and then freezes. The sequence direct load, indirect load, add, direct store, halt takes exactly 24 cycles. `halted_o` stays high until reset.
- R10: Opcodes 5, 6 and 7 act as halt: one word, 2 cycles, and the block stops.
- R11: With register field 0, a direct load changes no register and a direct store writes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin execution from address 0 when idle |
| halted_o | output | 1 | High once the program has halted |
| cycles_o | output | 16 | Cycles spent since start |
| r1_o | output | 16 | Register R1 |
| r2_o | output | 16 | Register R2 |
| r3_o | output | 16 | Register R3 |

## Verification
The effect of a store never appears on a port directly. Each store test therefore reads the target address back with a later direct load and checks the register that load fills. A zero register field makes a store write 0 over a nonzero word, so the load that follows tells that case apart from a store that was skipped. Register values are also sampled one cycle before and one cycle after the last execute cycle of an instruction, which pins the execute costs down exactly. Separate instances carry separate memory images, so add wrap-around, an undefined opcode and `start_i` pulses while running or halted can each be reached.

// File: rtl/wordseq_pkg.sv
package wordseq_pkg;
  localparam int WS_DW = 16;
  localparam int WS_AW = 8;
  localparam int WS_IW = (1 << WS_AW) * WS_DW;

  localparam logic [2:0] OP_HALT = 3'd0;
  localparam logic [2:0] OP_LDD  = 3'd1;
  localparam logic [2:0] OP_LDI  = 3'd2;
  localparam logic [2:0] OP_ADD  = 3'd3;
  localparam logic [2:0] OP_STD  = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_HALT} state_e;

  // Default image: direct load, indirect load, add, direct store, halt
  function automatic logic [WS_IW-1:0] demo_image();
    logic [WS_IW-1:0] img;
    img = '0;
    img[0*WS_DW +: WS_DW]    = 16'h2800;
    img[1*WS_DW +: WS_DW]    = 16'h0050;
    img[2*WS_DW +: WS_DW]    = 16'h4000;
    img[3*WS_DW +: WS_DW]    = 16'h6000;
    img[4*WS_DW +: WS_DW]    = 16'h9000;
    img[5*WS_DW +: WS_DW]    = 16'h0060;
    img[6*WS_DW +: WS_DW]    = 16'h0000;
    img[8'h50*WS_DW +: WS_DW] = 16'h0070;
    img[8'h70*WS_DW +: WS_DW] = 16'h1234;
    return img;
  endfunction
endpackage

// File: rtl/wordseq_mem.sv
module wordseq_mem #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [(1<<AW)*DW-1:0] IMAGE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= IMAGE[i*DW +: DW];
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // Access latency comes from sequencer wait states
  assign rdata_o = mem_q[addr_i];

  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/wordseq_regfile.sv
module wordseq_regfile #(
  parameter int DW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          sel_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [2:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < 3; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_o[g] <= '0;
      else if (we_i && sel_i == 2'(g + 1))      regs_o[g] <= wdata_i;
    end
  end

  a_r11_sel0_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd0) |=> $stable(regs_o));
  a_r6_idle_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/wordseq_seq.sv
module wordseq_seq
  import wordseq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int CW        = 16,
  parameter int FETCH_CYC = 2,
  parameter int XFER_CYC  = 3,
  parameter int ADD_CYC   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [AW-1:0]      mem_addr_o,
  output logic               mem_we_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               rf_we_o,
  output logic [1:0]         rf_sel_o,
  output logic [DW-1:0]      rf_wdata_o,
  input  logic [2:0][DW-1:0] regs_i,
  output logic               halted_o,
  output logic [CW-1:0]      cycles_o
);
  localparam int SW = (FETCH_CYC > 1) ? $clog2(FETCH_CYC) : 1;
  localparam int XW = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;

  state_e          state_q;
  logic [AW-1:0]   pc_q, addr_q;
  logic [4:0]      ir_q;          // opcode + register field
  logic            second_q;      // fetching second word
  logic [SW-1:0]   sub_q;
  logic [XW-1:0]   wait_q;
  logic [CW-1:0]   cycles_q;

  function automatic logic [XW-1:0] exec_wait(input logic [2:0] op);
    return (op == OP_ADD) ? XW'(ADD_CYC - 1) : XW'(XFER_CYC - 1);
  endfunction

  logic [2:0] fetched_op, ir_op;
  logic [1:0] ir_sel;
  logic       last_sub, two_word, ends_instr, halt_class, exec_done;

  always_comb begin
    fetched_op = second_q ? ir_q[4:2] : mem_rdata_i[15:13];
    ir_op      = ir_q[4:2];
    ir_sel     = ir_q[1:0];
    last_sub   = (sub_q == SW'(FETCH_CYC - 1));
    two_word   = (fetched_op == OP_LDD) || (fetched_op == OP_STD);
    ends_instr = second_q || !two_word;
    halt_class = (fetched_op == OP_HALT) || (fetched_op > OP_STD);
    exec_done  = (state_q == S_EXEC) && (wait_q == '0);
  end

  always_comb begin
    mem_addr_o = pc_q;
    if (state_q == S_EXEC)
      mem_addr_o = (ir_op == OP_LDI) ? regs_i[0][AW-1:0] : addr_q;
    case (ir_sel)
      2'd1:    mem_wdata_o = regs_i[0];
      2'd2:    mem_wdata_o = regs_i[1];
      2'd3:    mem_wdata_o = regs_i[2];
      default: mem_wdata_o = '0;
    endcase
    mem_we_o   = exec_done && (ir_op == OP_STD);
    rf_we_o    = exec_done && (ir_op == OP_LDD || ir_op == OP_LDI || ir_op == OP_ADD);
    rf_sel_o   = (ir_op == OP_LDD) ? ir_sel : 2'd2;
    rf_wdata_o = (ir_op == OP_ADD) ? regs_i[1] + regs_i[2] : mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pc_q     <= '0;
      addr_q   <= '0;
      ir_q     <= '0;
      second_q <= 1'b0;
      sub_q    <= '0;
      wait_q   <= '0;
      cycles_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_FETCH;
          pc_q     <= '0;
          sub_q    <= '0;
          second_q <= 1'b0;
          cycles_q <= '0;
        end
        S_FETCH: begin
          cycles_q <= cycles_q + 1'b1;
          if (!last_sub) begin
            sub_q <= sub_q + 1'b1;
          end else begin
            sub_q <= '0;
            pc_q  <= pc_q + 1'b1;
            if (!second_q) ir_q   <= mem_rdata_i[15:11];
            else           addr_q <= mem_rdata_i[AW-1:0];
            if (ends_instr) begin
              second_q <= 1'b0;
              wait_q   <= exec_wait(fetched_op);
              state_q  <= halt_class ? S_HALT : S_EXEC;
            end else begin
              second_q <= 1'b1;
            end
          end
        end
        S_EXEC: begin
          cycles_q <= cycles_q + 1'b1;
          if (wait_q != '0) wait_q <= wait_q - 1'b1;
          else              state_q <= S_FETCH;
        end
        default: ;
      endcase
    end
  end

  assign halted_o = (state_q == S_HALT);
  assign cycles_o = cycles_q;

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  a_r9_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(cycles_o));
  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH || state_q == S_EXEC) |=> cycles_o == $past(cycles_o) + CW'(1));
  a_r2_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && start_i) |=> state_q != S_IDLE);
  a_r4_pc_hold_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH && !last_sub) |=> $stable(pc_q));
  a_r5_pc_hold_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC) |=> $stable(pc_q));
endmodule

// File: rtl/wordseq_cpu.sv
module wordseq_cpu
  import wordseq_pkg::*;
#(
  parameter int DW        = WS_DW,
  parameter int AW        = WS_AW,
  parameter int CW        = 16,
  parameter int FETCH_CYC = 2,
  parameter int XFER_CYC  = 3,
  parameter int ADD_CYC   = 1,
  parameter logic [(1<<AW)*DW-1:0] IMAGE = demo_image()
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          halted_o,
  output logic [CW-1:0] cycles_o,
  output logic [DW-1:0] r1_o,
  output logic [DW-1:0] r2_o,
  output logic [DW-1:0] r3_o
);
  logic [AW-1:0]      mem_addr;
  logic               mem_we;
  logic [DW-1:0]      mem_wdata, mem_rdata;
  logic               rf_we;
  logic [1:0]         rf_sel;
  logic [DW-1:0]      rf_wdata;
  logic [2:0][DW-1:0] regs;

  wordseq_mem #(.DW(DW), .AW(AW), .IMAGE(IMAGE)) u_mem (
    .clk_i, .rst_ni,
    .addr_i  (mem_addr),
    .we_i    (mem_we),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  wordseq_regfile #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (rf_we),
    .sel_i   (rf_sel),
    .wdata_i (rf_wdata),
    .regs_o  (regs)
  );

  wordseq_seq #(
    .DW(DW), .AW(AW), .CW(CW),
    .FETCH_CYC(FETCH_CYC), .XFER_CYC(XFER_CYC), .ADD_CYC(ADD_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .mem_rdata_i (mem_rdata),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .rf_we_o     (rf_we),
    .rf_sel_o    (rf_sel),
    .rf_wdata_o  (rf_wdata),
    .regs_i      (regs),
    .halted_o,
    .cycles_o
  );

  assign r1_o = regs[0];
  assign r2_o = regs[1];
  assign r3_o = regs[2];
endmodule

// File: tb/wordseq_cpu_bench.sv
module wordseq_cpu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int IW = (1 << AW) * DW;
  localparam int WATCHDOG = 5000;

  function automatic logic [IW-1:0] put(input logic [IW-1:0] img, input int a, input logic [15:0] w);
    img[a*DW +: DW] = w;
    return img;
  endfunction

  // R3 encodings: op[15:13], reg[12:11]; address in second word
  function automatic logic [IW-1:0] img_b();
    logic [IW-1:0] m;
    m = '0;
    m = put(m, 0, 16'h3800);  m = put(m, 1, 16'h0040);   // R3 <= [40]
    m = put(m, 2, 16'h2800);  m = put(m, 3, 16'h0041);   // R1 <= [41]
    m = put(m, 4, 16'h4000);                             // R2 <= [R1]
    m = put(m, 5, 16'h6000);                             // R2 += R3
    m = put(m, 6, 16'h9000);  m = put(m, 7, 16'h0060);   // [60] <= R2
    m = put(m, 8, 16'h3800);  m = put(m, 9, 16'h0060);   // R3 <= [60]
    m = put(m, 10, 16'h0000);
    m = put(m, 'h40, 16'h0005);
    m = put(m, 'h41, 16'h0042);
    m = put(m, 'h42, 16'hFFFE);
    return m;
  endfunction

  function automatic logic [IW-1:0] img_c();
    logic [IW-1:0] m;
    m = '0;
    m = put(m, 0, 16'h8000);  m = put(m, 1, 16'h0011);   // [11] <= none
    m = put(m, 2, 16'h2800);  m = put(m, 3, 16'h0011);   // R1 <= [11]
    m = put(m, 4, 16'h2000);  m = put(m, 5, 16'h0012);   // none <= [12]
    m = put(m, 6, 16'hC000);                             // opcode 6
    m = put(m, 7, 16'h3000);  m = put(m, 8, 16'h0012);   // never reached
    m = put(m, 'h11, 16'hBEEF);
    m = put(m, 'h12, 16'h7777);
    return m;
  endfunction

  localparam logic [IW-1:0] IMG_B = img_b();
  localparam logic [IW-1:0] IMG_C = img_c();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0, start_c = 1'b0;
  logic        halt_a, halt_b, halt_c;
  logic [15:0] cyc_a, cyc_b, cyc_c;
  logic [15:0] a1, a2, a3, b1, b2, b3, c1, c2, c3;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordseq_cpu u_wordseq_cpu (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .halted_o(halt_a),
    .cycles_o(cyc_a), .r1_o(a1), .r2_o(a2), .r3_o(a3)
  );
  wordseq_cpu #(.IMAGE(IMG_B)) u_wordseq_cpu_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .halted_o(halt_b),
    .cycles_o(cyc_b), .r1_o(b1), .r2_o(b2), .r3_o(b3)
  );
  wordseq_cpu #(.IMAGE(IMG_C)) u_wordseq_cpu_c (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_c), .halted_o(halt_c),
    .cycles_o(cyc_c), .r1_o(c1), .r2_o(c2), .r3_o(c3)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "A halted in reset", 32'(halt_a), 0);
    chk("R1", "A cycles in reset", 32'(cyc_a), 0);
    chk("R1", "A regs in reset", {a1, a2 | a3}, 0);
    step(1);
    rst_n = 1'b1;
    step(3);
    chk("R1", "B idle count", 32'(cyc_b), 0);
    chk("R1", "C idle halted", 32'(halt_c), 0);
    chk("R1", "B regs idle", {b1 | b2, b3}, 0);
  endtask

  task automatic t_reference();
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    chk("R2", "A count after start", 32'(cyc_a), 0);
    step(6);
    chk("R5", "R1 before load done", 32'(a1), 0);
    step(1);
    chk("R6", "R1 after direct load", 32'(a1), 32'h70);
    chk("R4", "count after 2-word load", 32'(cyc_a), 7);
    step(4);
    chk("R5", "R2 before indirect done", 32'(a2), 0);
    step(1);
    chk("R6", "R2 after indirect load", 32'(a2), 32'h1234);
    step(11);
    chk("R9", "not halted at 23", 32'(halt_a), 0);
    chk("R9", "count at 23", 32'(cyc_a), 23);
    step(1);
    chk("R9", "halted at 24", 32'(halt_a), 1);
    chk("R9", "total 24", 32'(cyc_a), 24);
    chk("R7", "R2 after add with zero R3", 32'(a2), 32'h1234);
    step(10);
    chk("R9", "count frozen", 32'(cyc_a), 24);
    chk("R9", "halt sticky", 32'(halt_a), 1);
  endtask

  task automatic t_wrap_store();
    @(negedge clk) start_b = 1'b1;
    @(negedge clk) start_b = 1'b0;
    step(10);
    @(negedge clk) start_b = 1'b1;   // R2: ignored while running
    @(negedge clk) start_b = 1'b0;
    step(7);
    chk("R6", "B R2 indirect", 32'(b2), 32'hFFFE);
    step(2);
    chk("R5", "B R2 before add done", 32'(b2), 32'hFFFE);
    step(1);
    chk("R7", "B add wraps", 32'(b2), 32'h0003);
    chk("R5", "B add 1 cycle", 32'(cyc_b), 22);
    step(15);
    chk("R2", "B not halted at 37", 32'(halt_b), 0);
    step(1);
    chk("R2", "B total unaffected by start", 32'(cyc_b), 38);
    chk("R9", "B halted", 32'(halt_b), 1);
    chk("R8", "B store then load", 32'(b3), 32'h0003);
    chk("R6", "B R1", 32'(b1), 32'h0042);
  endtask

  task automatic t_field0_undef();
    @(negedge clk) start_c = 1'b1;
    @(negedge clk) start_c = 1'b0;
    step(22);
    chk("R10", "C not halted at 22", 32'(halt_c), 0);
    step(1);
    chk("R10", "undefined opcode halts", 32'(halt_c), 1);
    chk("R10", "C total 23", 32'(cyc_c), 23);
    chk("R11", "store of field 0 wrote zero", 32'(c1), 0);
    chk("R11", "load to field 0 discarded", {c2, c3}, 0);
    @(negedge clk) start_c = 1'b1;
    @(negedge clk) start_c = 1'b0;
    step(5);
    chk("R2", "start ignored when halted", 32'(cyc_c), 23);
    chk("R2", "C halt kept", 32'(halt_c), 1);
  endtask

  task automatic t_rerun();
    @(negedge clk) rst_n = 1'b0;
    step(1);
    chk("R1", "A halted cleared", 32'(halt_a), 0);
    chk("R1", "A count cleared", 32'(cyc_a), 0);
    chk("R1", "A regs cleared", {a1, a2}, 0);
    rst_n = 1'b1;
    step(1);
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    step(24);
    chk("R9", "rerun total 24", 32'(cyc_a), 24);
    chk("R1", "rerun image restored", 32'(a2), 32'h1234);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      begin
        t_reset();
        t_reference();
        t_wrap_store();
        t_field0_undef();
        t_rerun();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule